// File: doc/BRIEF.md
# Missing Pulse and Envelope Detector

This block watches a pulse train that is already synchronous to its clock. Each rising edge of the train restarts a retriggerable timeout whose length, in clock cycles, comes from an input value. The user sets that value a little above the expected spacing of the pulses. While the pulses keep arriving in time, the timeout never runs out and the envelope output stays high. Once the train stops or a pulse is late, the envelope falls.

The end of the timeout, not any input edge, fires a second timer. That timer drives an alarm output high for a programmable number of cycles. The alarm marks the cycle in which the expected pulse failed to arrive, so a burst detector and a missing pulse detector come from the same pair of timers.

Top module: `gap_watch`

## Requirements
- R1: A rising edge on `pulse_in` (low in the previous clock, high in this one) loads the timeout counter with `timeout_cyc`, whatever the counter held before.
- R2: After the clock edge that captures a rising edge, `envelope` is high for exactly `timeout_cyc` cycles. A train whose rising edges are at most `timeout_cyc` cycles apart keeps `envelope` high without a gap.
- R3: `alarm` never rises while rising edges keep arriving at most `timeout_cyc` cycles apart.
- R4: When the timeout expires with no new rising edge, `alarm` goes high in the first cycle that `envelope` is low. It stays high for `alarm_len` cycles, the value sampled at the expiry edge.
- R5: An `alarm_len` of 0 gives a one-cycle alarm.
- R6: A single expiry produces exactly one alarm pulse. An idle input produces no further alarms.
- R7: `pulse_in` held high counts as a single rising edge. A level that stays high does not extend `envelope`.
- R8: With `timeout_cyc` equal to 0, a rising edge leaves `envelope` low and raises no alarm.
- R9: A high `rst` at a clock edge clears both timers. After that edge `envelope` and `alarm` are low.
- R10: An expiry that occurs while an alarm is still running reloads the alarm length from the new expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Pulse train, synchronous to `clk` |
| timeout_cyc | input | 16 | Timeout length in cycles, taken at each rising edge |
| alarm_len | input | 16 | Alarm pulse length in cycles, taken at expiry (0 acts as 1) |
| envelope | output | 1 | High while the timeout is running |
| alarm | output | 1 | Missing pulse indicator |

## Verification
A timeout counter that was loaded or decremented wrongly shows up directly on `envelope`. The fall comes early or late, and the bench sees it in the first cycle where it differs from the reference. A fault in the edge detection shows up as a held-high input that stretches `envelope`. The expiry decode and the alarm counter show up one cycle after the timeout ends, as a missing, misplaced, repeated or mis-sized `alarm` pulse.

// File: rtl/gw_pkg.sv
package gw_pkg;

  // Counter step shared by both timers: reload wins, else count down to zero.
  function automatic logic [15:0] gw_step(input logic [15:0] cur,
                                          input logic        reload,
                                          input logic [15:0] value);
    if (reload)         return value;
    else if (cur != '0) return cur - 16'd1;
    else                return cur;
  endfunction

  // Alarm length with the one-cycle floor.
  function automatic logic [15:0] gw_alarm_len(input logic [15:0] w);
    return (w == '0) ? 16'd1 : w;
  endfunction

endpackage

// File: rtl/gw_edge_detect.sv
module gw_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_in;
  end

  assign rise = sig_in & ~prev_q;

  // R7: a rise cannot be seen on two consecutive cycles
  assert_single_rise_R7: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/gw_retrig_timer.sv
module gw_retrig_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  output logic             active,
  output logic             expire
);
  import gw_pkg::*;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= gw_step(cnt_q, restart, load_val);
  end

  assign active = (cnt_q != '0);
  assign expire = (cnt_q == CNT_W'(1)) && !restart;

  assert_restart_load_R1: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt_q == $past(load_val));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!restart && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/gw_alarm_shot.sv
module gw_alarm_shot #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CNT_W-1:0] width,
  output logic             pulse
);
  import gw_pkg::*;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= gw_step(cnt_q, fire, gw_alarm_len(width));
  end

  assign pulse = (cnt_q != '0);

  assert_len_floor_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && width == '0) |=> cnt_q == CNT_W'(1));
  assert_reload_R10: assert property (@(posedge clk) disable iff (rst)
    (fire && width != '0) |=> cnt_q == $past(width));
endmodule

// File: rtl/gap_watch.sv
module gap_watch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_in,
  input  logic [CNT_W-1:0] timeout_cyc,
  input  logic [CNT_W-1:0] alarm_len,
  output logic             envelope,
  output logic             alarm
);
  // named internal events
  logic ev_rise;
  logic ev_expire;

  gw_edge_detect u_edge (
    .clk(clk), .rst(rst), .sig_in(pulse_in), .rise(ev_rise)
  );

  gw_retrig_timer #(.CNT_W(CNT_W)) u_timeout (
    .clk(clk), .rst(rst), .restart(ev_rise), .load_val(timeout_cyc),
    .active(envelope), .expire(ev_expire)
  );

  gw_alarm_shot #(.CNT_W(CNT_W)) u_alarm (
    .clk(clk), .rst(rst), .fire(ev_expire), .width(alarm_len),
    .pulse(alarm)
  );

  assert_alarm_after_expire_R4: assert property (@(posedge clk) disable iff (rst)
    ev_expire |=> (alarm && !envelope));
  assert_alarm_only_on_drop_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> $fell(envelope));
  assert_zero_timeout_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_rise && timeout_cyc == '0) |=> !envelope);
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!envelope && !alarm));
endmodule

// File: tb/gap_watch_tb.sv
module gap_watch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pulse_in = 1'b0;
  logic [15:0] timeout_cyc = 16'd0;
  logic [15:0] alarm_len = 16'd0;
  logic        envelope, alarm;

  gap_watch dut_i (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .timeout_cyc(timeout_cyc),
    .alarm_len(alarm_len), .envelope(envelope), .alarm(alarm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int clocks  = 0;
  string tag = "R9";

  // reference model state: edge times and deadlines, in clock-edge indices
  int  edge_idx = 0;
  bit  m_prev = 0;
  bit  m_seen = 0;
  int  m_last = 0;
  int  m_tlen = 0;
  int  m_alarm_until = 0;
  int  alarm_rises = 0;
  bit  alarm_was = 0;

  task automatic model_edge(bit r, bit p, int t, int w);
    bit rise_now, exp_now;
    if (r) begin
      m_prev = 0; m_seen = 0; m_alarm_until = 0;
    end else begin
      rise_now = p && !m_prev;
      exp_now  = m_seen && !rise_now && ((edge_idx - m_last) == m_tlen) && (m_tlen > 0);
      if (rise_now) begin m_seen = 1; m_last = edge_idx; m_tlen = t; end
      if (exp_now)  m_alarm_until = edge_idx + ((w == 0) ? 1 : w);
      m_prev = p;
    end
  endtask

  function automatic bit exp_env();
    return m_seen && ((edge_idx - m_last) < m_tlen);
  endfunction

  function automatic bit exp_alarm();
    return edge_idx < m_alarm_until;
  endfunction

  task automatic compare();
    vectors++;
    if (envelope !== exp_env()) begin
      errors++;
      $display("FAIL %s envelope actual=%b expected=%b at edge %0d", tag, envelope, exp_env(), edge_idx);
    end
    vectors++;
    if (alarm !== exp_alarm()) begin
      errors++;
      $display("FAIL %s alarm actual=%b expected=%b at edge %0d", tag, alarm, exp_alarm(), edge_idx);
    end
    if (alarm && !alarm_was) alarm_rises++;
    alarm_was = alarm;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit r, bit p);
    rst = r; pulse_in = p;
    @(posedge clk);
    model_edge(r, p, timeout_cyc, alarm_len);
    @(negedge clk);
    compare();
    edge_idx++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic train(int count, int period);
    for (int k = 0; k < count; k++) begin
      step(0, 1);
      for (int j = 1; j < period; j++) step(0, 0);
    end
  endtask

  task automatic expect_rises(int n, string rq);
    vectors++;
    if (alarm_rises != n) begin
      errors++;
      $display("FAIL %s alarm pulse count actual=%0d expected=%0d", rq, alarm_rises, n);
    end
    alarm_rises = 0;
  endtask

  always @(posedge clk) begin
    clocks++;
    if (clocks > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d clocks", clocks, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tag = "R9"; step(1, 0); step(1, 1);
    alarm_rises = 0;

    // R2 R3: steady train, period 5, timeout 7
    timeout_cyc = 16'd7; alarm_len = 16'd3;
    tag = "R3"; train(20, 5); expect_rises(0, "R3");
    // R4 R6: train stops, one alarm of 3 cycles, none later
    tag = "R4"; idle(30); expect_rises(1, "R6");

    // R2: period equal to timeout still continuous
    tag = "R2"; train(10, 7); expect_rises(0, "R2");
    tag = "R4"; idle(20); expect_rises(1, "R4");

    // R5: zero alarm length gives one cycle
    alarm_len = 16'd0; tag = "R5"; train(3, 4); idle(15); expect_rises(1, "R5");

    // R1: late pulse; restart after expiry
    alarm_len = 16'd2; tag = "R1"; train(2, 9); idle(10); expect_rises(2, "R1");

    // R7: level held high
    timeout_cyc = 16'd4; tag = "R7";
    for (int i = 0; i < 12; i++) step(0, 1);
    step(0, 0); idle(10); expect_rises(1, "R7");

    // R8: zero timeout
    timeout_cyc = 16'd0; tag = "R8"; train(5, 3); idle(8); expect_rises(0, "R8");

    // R10: expiry during a running alarm reloads it
    timeout_cyc = 16'd3; alarm_len = 16'd10; tag = "R10";
    step(0, 1); idle(5); step(0, 1); idle(25); expect_rises(1, "R10");

    // R9: reset in the middle of activity
    timeout_cyc = 16'd6; alarm_len = 16'd4; tag = "R9";
    train(3, 4); step(1, 0); idle(12); expect_rises(0, "R9");
    train(2, 3); idle(3); step(1, 0); idle(10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule